// File: doc/BRIEF.md
# Configurable SPI Master Serializer

This block is the serial engine of an SPI master. Software places a character in a one-entry transmit buffer. The engine shifts that character out on the data-out line and, in the same frame, shifts in a character from the data-in line. The received character is placed in a one-entry receive buffer. Static configuration inputs select the following:

- the idle level of the serial clock;
- whether data is launched on the leading or the trailing edge;
- whether the most or the least significant bit goes first;
- whether characters are 7 or 8 bits wide;
- how the slave-enable pin behaves.

The slave-enable pin has three modes. It can be unused. It can drive an active-high or active-low select to the slave. In either 4-pin polarity it can instead be an input that watches for a competing master. A contention seen on that input latches a conflict flag and blocks new frames. A listen option routes the outgoing bit stream back into the receiver, so the engine can test itself without a slave.

Timing comes from a 16-bit divider. Each half of a serial clock period lasts `D` system cycles, where `D` is the divider value and 0 counts as 1. A frame of `N` bits keeps the busy flag high for exactly `2*N*D + 1` system cycles.

A soft-reset input clears the engine and both buffers while it is held high.

Top module: `spi_master_core`

## Requirements
- R1: While no frame is in progress, `sclk` rests at `cfgPolarity` (0 = low, 1 = high).
- R2: With `cfgPhase`=0 a bit is presented before the first clock edge, captured on odd edges and changed on even edges. With `cfgPhase`=1 a bit is changed on odd edges and captured on even edges. Edges are counted from 1 within a frame.
- R3: `cfgMsbFirst`=1 sends and assembles the character most significant bit first. `cfgMsbFirst`=0 does both least significant bit first.
- R4: `cfgSevenBit`=1 moves 7-bit characters (bits 6..0), and `rxData` bit 7 reads 0. `cfgSevenBit`=0 moves 8-bit characters.
- R5: `cfgPinMode` 00 (3-pin) and 11 leave `steOe` at 0. In modes 01 (active high) and 10 (active low) with `cfgSelDrive`=1, `steOe` is 1 and `steOut` sits at the active level while busy and at the inactive level while idle.
- R6: In modes 01 or 10 with `cfgSelDrive`=0, `steIn` at the active level sets the sticky `conflict` flag. While `conflict` is set, no frame starts and the transmit buffer stays full.
- R7: `busy` stays high for exactly `2*N*D + 1` cycles per frame. Here `N` is the character length and `D` is `cfgDivider`, with 0 used as 1.
- R8: `txEmpty` drops in the cycle after `txWrite` and returns to 1 in the cycle after that, when the character moves into the shifter and `busy` rises.
- R9: `rxFull` is set when a frame completes and cleared by `rxRead`. If a frame completes while `rxFull` is still set, `overrun` is set and `rxData` takes the newest character. `rxRead` also clears `overrun`.
- R10: With `cfgListen`=1 the received character equals the transmitted one, whatever `miso` carries.
- R11: While `cfgSoftRst`=1 the flags and buffers are cleared (`txEmpty`=1, `rxFull`=0, `overrun`=0, `conflict`=0), `sclk` holds its idle level and `txWrite` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSoftRst | input | 1 | Holds the engine cleared while 1 |
| cfgPolarity | input | 1 | Idle level of the serial clock |
| cfgPhase | input | 1 | 0: launch before first edge; 1: launch on first edge |
| cfgMsbFirst | input | 1 | 1: MSB first, 0: LSB first |
| cfgSevenBit | input | 1 | 1: 7-bit characters, 0: 8-bit |
| cfgPinMode | input | 2 | 00 3-pin, 01 enable active high, 10 enable active low |
| cfgSelDrive | input | 1 | 1: drive slave enable, 0: detect other master |
| cfgListen | input | 1 | Internal loopback of data-out to data-in |
| cfgDivider | input | 16 | System cycles per serial half period |
| txWrite | input | 1 | Writes `txData` into the transmit buffer |
| txData | input | 8 | Character to send |
| rxRead | input | 1 | Acknowledges the receive buffer |
| rxData | output | 8 | Last received character |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| steIn | input | 1 | Slave-enable pin sensed as input |
| steOut | output | 1 | Slave-enable level driven |
| steOe | output | 1 | Slave-enable output enable |
| busy | output | 1 | Frame in progress |
| txEmpty | output | 1 | Transmit buffer empty |
| rxFull | output | 1 | Receive buffer holds an unread character |
| overrun | output | 1 | A character was overwritten unread |
| conflict | output | 1 | Another master was detected |

## Verification
A bench slave counts clock edges and drives or samples data according to the configured phase. It rebuilds the sent word and supplies its own word, so each frame checks both directions at once.

Frames are run across all four polarity and phase combinations, both bit orders, both character lengths and divider values 0, 1 and 2. A wrong edge choice corrupts the rebuilt word. A wrong order shows up as a bit-reversed word. A wrong divider changes the measured busy length.

The remaining scenarios separate the buffer and select logic from the shifter:
- paired frames without a read expose the overrun and overwrite rules;
- loopback with a silent slave separates `mosi` from `miso`;
- each select mode checks the driven level while busy and while idle;
- a detected master checks that frames are held off until soft reset.

// File: rtl/spi_pkg.sv
package spi_pkg;
  // strobes from the sequencer to the shifter datapath
  typedef struct packed {
    logic load;      // move transmit buffer into shifter
    logic shiftOut;  // advance the outgoing bit
    logic capture;   // sample the incoming bit
    logic finish;    // deposit received character
  } spi_strobe_t;
endpackage

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             cfgPolarity,
  input  logic             cfgPhase,
  input  logic             cfgSevenBit,
  input  logic [1:0]       cfgPinMode,
  input  logic             cfgSelDrive,
  input  logic [DIV_W-1:0] cfgDivider,
  input  logic             steIn,
  input  logic             txPending,
  output spi_strobe_t      strobe,
  output logic             sclk,
  output logic             steOut,
  output logic             steOe,
  output logic             busy,
  output logic             conflict
);
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} state_t;

  state_t            state;
  logic [DIV_W-1:0]  baudCnt, divEff;
  logic [EDGE_W-1:0] edgeCnt, nextEdge, lastEdge;
  logic              tick, leading, fourPin, activeLvl, steSeen, conflictReg, sclkReg;

  assign divEff   = (cfgDivider == '0) ? DIV_W'(1) : cfgDivider;
  assign lastEdge = cfgSevenBit ? EDGE_W'(2 * (DATA_W - 1)) : EDGE_W'(2 * DATA_W);
  assign nextEdge = EDGE_W'(edgeCnt + 1'b1);
  assign leading  = nextEdge[0];
  assign tick     = (state == ST_SHIFT) && (baudCnt == DIV_W'(divEff - 1'b1));

  assign fourPin   = (cfgPinMode == 2'b01) || (cfgPinMode == 2'b10);
  assign activeLvl = (cfgPinMode == 2'b01);
  assign steSeen   = fourPin && !cfgSelDrive && (steIn == activeLvl);

  assign strobe.load     = (state == ST_IDLE) && txPending && !conflictReg && !steSeen && !softRst;
  assign strobe.capture  = tick && (cfgPhase ? !leading : leading);
  assign strobe.shiftOut = tick && (cfgPhase ? (leading && nextEdge != EDGE_W'(1))
                                             : (!leading && nextEdge != lastEdge));
  assign strobe.finish   = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      baudCnt     <= '0;
      edgeCnt     <= '0;
      sclkReg     <= 1'b0;
      conflictReg <= 1'b0;
    end else if (softRst) begin
      state       <= ST_IDLE;
      baudCnt     <= '0;
      edgeCnt     <= '0;
      sclkReg     <= cfgPolarity;
      conflictReg <= 1'b0;
    end else begin
      if (steSeen) conflictReg <= 1'b1;
      case (state)
        ST_IDLE: begin
          sclkReg <= cfgPolarity;
          baudCnt <= '0;
          edgeCnt <= '0;
          if (strobe.load) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            baudCnt <= '0;
            edgeCnt <= nextEdge;
            sclkReg <= ~sclkReg;
            if (nextEdge == lastEdge) state <= ST_DONE;
          end else begin
            baudCnt <= baudCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk     = sclkReg;
  assign busy     = (state != ST_IDLE);
  assign conflict = conflictReg;
  assign steOe    = fourPin && cfgSelDrive;
  assign steOut   = steOe && (busy ? activeLvl : !activeLvl);

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state == ST_IDLE) && $past(rstN) && $stable(cfgPolarity))
      |-> sclk == cfgPolarity);

  // R6
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && conflictReg && !softRst) |=> state == ST_IDLE);

  // R7
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> edgeCnt < lastEdge);
endmodule

// File: rtl/spi_datapath.sv
module spi_datapath
  import spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  spi_strobe_t       strobe,
  input  logic              cfgMsbFirst,
  input  logic              cfgSevenBit,
  input  logic              cfgListen,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              txPending,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              overrun
);
  localparam logic [DATA_W-1:0] SHORT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] txBuf, txShift, rxShift, rxBuf;
  logic              txFull, rxFullReg, overrunReg, rxBit;

  assign mosi  = cfgMsbFirst ? (cfgSevenBit ? txShift[DATA_W-2] : txShift[DATA_W-1])
                             : txShift[0];
  assign rxBit = cfgListen ? mosi : miso;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf      <= '0;
      txShift    <= '0;
      rxShift    <= '0;
      rxBuf      <= '0;
      txFull     <= 1'b0;
      rxFullReg  <= 1'b0;
      overrunReg <= 1'b0;
    end else if (softRst) begin
      txShift    <= '0;
      rxShift    <= '0;
      rxBuf      <= '0;
      txFull     <= 1'b0;
      rxFullReg  <= 1'b0;
      overrunReg <= 1'b0;
    end else begin
      if (txWrite) begin
        txBuf  <= txData;
        txFull <= 1'b1;
      end else if (strobe.load) begin
        txFull <= 1'b0;
      end
      if (strobe.load) txShift <= txBuf;
      else if (strobe.shiftOut)
        txShift <= cfgMsbFirst ? (txShift << 1) : (txShift >> 1);
      if (strobe.capture) begin
        if (cfgMsbFirst)      rxShift <= {rxShift[DATA_W-2:0], rxBit};
        else if (cfgSevenBit) rxShift <= {1'b0, rxBit, rxShift[DATA_W-2:1]};
        else                  rxShift <= {rxBit, rxShift[DATA_W-1:1]};
      end
      if (rxRead) begin
        rxFullReg  <= 1'b0;
        overrunReg <= 1'b0;
      end
      if (strobe.finish) begin
        rxBuf     <= cfgSevenBit ? (rxShift & SHORT_MASK) : rxShift;
        rxFullReg <= 1'b1;
        if (rxFullReg && !rxRead) overrunReg <= 1'b1;
      end
    end
  end

  assign rxData    = rxBuf;
  assign txPending = txFull;
  assign txEmpty   = !txFull;
  assign rxFull    = rxFullReg;
  assign overrun   = overrunReg;

  // R8
  tx_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) |-> $past(txWrite));

  // R9
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(rxRead || softRst));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFull && strobe.finish));
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSoftRst,
  input  logic              cfgPolarity,
  input  logic              cfgPhase,
  input  logic              cfgMsbFirst,
  input  logic              cfgSevenBit,
  input  logic [1:0]        cfgPinMode,
  input  logic              cfgSelDrive,
  input  logic              cfgListen,
  input  logic [DIV_W-1:0]  cfgDivider,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  input  logic              steIn,
  output logic              steOut,
  output logic              steOe,
  output logic              busy,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              overrun,
  output logic              conflict
);
  spi_strobe_t strobe;
  logic        txPending;

  spi_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .softRst(cfgSoftRst),
    .cfgPolarity(cfgPolarity), .cfgPhase(cfgPhase), .cfgSevenBit(cfgSevenBit),
    .cfgPinMode(cfgPinMode), .cfgSelDrive(cfgSelDrive), .cfgDivider(cfgDivider),
    .steIn(steIn), .txPending(txPending), .strobe(strobe),
    .sclk(sclk), .steOut(steOut), .steOe(steOe), .busy(busy), .conflict(conflict)
  );

  spi_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .softRst(cfgSoftRst), .strobe(strobe),
    .cfgMsbFirst(cfgMsbFirst), .cfgSevenBit(cfgSevenBit), .cfgListen(cfgListen),
    .txWrite(txWrite), .txData(txData), .rxRead(rxRead), .miso(miso),
    .mosi(mosi), .rxData(rxData), .txPending(txPending), .txEmpty(txEmpty),
    .rxFull(rxFull), .overrun(overrun)
  );
endmodule

// File: tb/test_spi_master_core.sv
module test_spi_master_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgSoftRst = 0, cfgPolarity = 0, cfgPhase = 0, cfgMsbFirst = 1, cfgSevenBit = 0;
  logic [1:0] cfgPinMode = 2'b00;
  logic cfgSelDrive = 1, cfgListen = 0;
  logic [15:0] cfgDivider = 16'd2;
  logic txWrite = 0, rxRead = 0, miso = 0, steIn = 1;
  logic [7:0] txData = '0;
  logic [7:0] rxData;
  logic sclk, mosi, steOut, steOe, busy, txEmpty, rxFull, overrun, conflict;

  spi_master_core i_spi_master_core (
    .clk(clk), .rstN(rstN), .cfgSoftRst(cfgSoftRst), .cfgPolarity(cfgPolarity),
    .cfgPhase(cfgPhase), .cfgMsbFirst(cfgMsbFirst), .cfgSevenBit(cfgSevenBit),
    .cfgPinMode(cfgPinMode), .cfgSelDrive(cfgSelDrive), .cfgListen(cfgListen),
    .cfgDivider(cfgDivider), .txWrite(txWrite), .txData(txData), .rxRead(rxRead),
    .rxData(rxData), .sclk(sclk), .mosi(mosi), .miso(miso), .steIn(steIn),
    .steOut(steOut), .steOe(steOe), .busy(busy), .txEmpty(txEmpty), .rxFull(rxFull),
    .overrun(overrun), .conflict(conflict)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [7:0] txExp;
    logic [7:0] rxExp;
    int         busyExp;
  } item_t;
  item_t scoreQ[$];

  int checkCnt = 0, failCnt = 0, busyCnt = 0;
  logic [7:0] slaveWord = '0, mosiWord = '0;
  int edgeIdx = 0, chgIdx = 0, capIdx = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nBits();
    return cfgSevenBit ? 7 : 8;
  endfunction

  function automatic logic bitAt(input logic [7:0] w, input int i);
    return cfgMsbFirst ? w[nBits() - 1 - i] : w[i];
  endfunction

  // slave model: counts edges and follows the phase rules of R2
  always @(posedge busy) begin
    edgeIdx = 0; chgIdx = 0; capIdx = 0; mosiWord = '0;
    if (!cfgPhase) miso = bitAt(slaveWord, 0);
  end

  always @(sclk) begin
    if (busy) begin
      edgeIdx++;
      if (cfgPhase ? (edgeIdx % 2 == 0) : (edgeIdx % 2 == 1)) begin
        if (capIdx < nBits()) mosiWord[cfgMsbFirst ? nBits() - 1 - capIdx : capIdx] = mosi;
        capIdx++;
      end else begin
        if (cfgPhase) begin
          if (chgIdx < nBits()) miso = bitAt(slaveWord, chgIdx);
        end else begin
          if (chgIdx + 1 < nBits()) miso = bitAt(slaveWord, chgIdx + 1);
        end
        chgIdx++;
      end
    end
  end

  always @(negedge clk) if (busy) busyCnt++;

  // monitor: compares each finished frame against the scoreboard
  always @(negedge busy) begin
    if (rstN && !cfgSoftRst) begin
      item_t it;
      @(negedge clk);
      if (scoreQ.size() == 0) begin
        check(0, "R2 unexpected frame", 1, 0);
      end else begin
        it = scoreQ.pop_front();
        check(mosiWord == it.txExp, "R2/R3/R4 mosi word", mosiWord, it.txExp);
        check(rxData == it.rxExp, "R2/R3/R10 rxData", rxData, it.rxExp);
        check(busyCnt == it.busyExp, "R7 busy length", busyCnt, it.busyExp);
      end
      busyCnt = 0;
    end
  end

  task automatic sendChar(input logic [7:0] tx, input logic [7:0] slv, input bit doRead);
    item_t it;
    logic [7:0] mask;
    int d;
    logic expOe, actLvl;
    mask = cfgSevenBit ? 8'h7F : 8'hFF;
    d = (cfgDivider == 0) ? 1 : int'(cfgDivider);
    it.txExp = tx & mask;
    it.rxExp = cfgListen ? (tx & mask) : (slv & mask);
    it.busyExp = 2 * nBits() * d + 1;
    scoreQ.push_back(it);
    slaveWord = slv;
    expOe = (cfgPinMode == 2'b01 || cfgPinMode == 2'b10) && cfgSelDrive;
    actLvl = (cfgPinMode == 2'b01);
    @(negedge clk); txWrite = 1; txData = tx;
    @(negedge clk); txWrite = 0;
    check(!txEmpty, "R8 txEmpty after write", txEmpty, 0);
    @(negedge clk);
    check(txEmpty && busy, "R8 txEmpty at start", {txEmpty, busy}, 2'b11);
    check(steOe == expOe && steOut == (expOe & actLvl), "R5 select while busy",
          {steOe, steOut}, {expOe, expOe & actLvl});
    wait (!busy);
    @(negedge clk); @(negedge clk);
    check(rxFull, "R9 rxFull after frame", rxFull, 1);
    check(steOe == expOe && steOut == (expOe & !actLvl), "R5 select idle",
          {steOe, steOut}, {expOe, expOe & !actLvl});
    if (doRead) begin
      rxRead = 1; @(negedge clk); rxRead = 0;
      check(!rxFull && !overrun, "R9 read clears", {rxFull, overrun}, 0);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL R7 watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(sclk == 0 && !busy, "R1 reset idle clock", {sclk, busy}, 0);
    check(txEmpty && !rxFull && !overrun && !conflict, "R8/R9 reset flags",
          {txEmpty, rxFull, overrun, conflict}, 4'b1000);

    // polarity 0, phase 0, MSB first, 8-bit
    sendChar(8'hA5, 8'h3C, 1);
    cfgPhase = 1;
    sendChar(8'h5A, 8'hC3, 1);
    // idle level follows polarity
    cfgPolarity = 1; cfgPhase = 0; cfgMsbFirst = 0;
    @(negedge clk); @(negedge clk);
    check(sclk == 1, "R1 idle high", sclk, 1);
    sendChar(8'h96, 8'h2D, 1);
    // polarity 1, phase 1, 7-bit MSB first, divider 1
    cfgPhase = 1; cfgMsbFirst = 1; cfgSevenBit = 1; cfgDivider = 16'd1;
    sendChar(8'hE7, 8'h55, 1);
    check(rxData[7] == 0, "R4 short char top bit", rxData[7], 0);
    // divider 0 acts as 1, LSB first 7-bit
    cfgPolarity = 0; cfgPhase = 0; cfgMsbFirst = 0; cfgDivider = 16'd0;
    sendChar(8'hCB, 8'h9F, 1);
    // select modes
    cfgSevenBit = 0; cfgDivider = 16'd2; cfgPinMode = 2'b01;
    sendChar(8'h11, 8'hEE, 1);
    cfgPinMode = 2'b10; cfgMsbFirst = 1;
    sendChar(8'h81, 8'h7E, 1);
    // loopback ignores miso
    cfgPinMode = 2'b00; cfgListen = 1;
    sendChar(8'hC6, 8'h00, 1);
    cfgListen = 0;
    // overrun
    sendChar(8'h12, 8'h34, 0);
    check(!overrun, "R9 no overrun after one", overrun, 0);
    sendChar(8'h56, 8'h78, 0);
    check(overrun, "R9 overrun set", overrun, 1);
    rxRead = 1; @(negedge clk); rxRead = 0;
    check(!overrun && !rxFull, "R9 read clears overrun", {overrun, rxFull}, 0);
    // conflict detection, active-low input
    cfgPinMode = 2'b10; cfgSelDrive = 0; steIn = 0;
    @(negedge clk); @(negedge clk);
    check(conflict && !steOe, "R6 conflict seen", {conflict, steOe}, 2'b10);
    steIn = 1;
    txWrite = 1; txData = 8'h3F; @(negedge clk); txWrite = 0;
    repeat (20) @(negedge clk);
    check(!busy && !txEmpty && conflict, "R6 start blocked", {busy, txEmpty, conflict}, 3'b001);
    // soft reset
    cfgSoftRst = 1; @(negedge clk);
    txWrite = 1; txData = 8'h01; @(negedge clk); txWrite = 0;
    check(!conflict && txEmpty && !rxFull && sclk == cfgPolarity, "R11 soft reset clears",
          {conflict, txEmpty, rxFull}, 3'b010);
    cfgSoftRst = 0;
    repeat (3) @(negedge clk);
    check(txEmpty && !busy, "R11 write ignored", {txEmpty, busy}, 2'b10);
    repeat (2) @(negedge clk);
    check(scoreQ.size() == 0, "R2 scoreboard drained", scoreQ.size(), 0);
    finishRun();
  end
endmodule